// File: doc/BRIEF.md
# Byte-Wide Load/Store Sequencer

This block sits after the execute stage of a 16-bit processor. It turns load and store requests into accesses on two memories that are each one byte wide. One is a data RAM that can be read and written. The other is a separate program ROM that can only be read. Each space has its own 16-bit address. A request carries four things: an operation code, an address taken from a register, a source register value and the old value of the destination register. The block then runs one or two byte cycles on the right memory and ends with a one-cycle done pulse. For loads, the done pulse comes with a 16-bit write-back value.

Words are little-endian. The byte at the base address is bits 7:0 and the byte at base+1 is bits 15:8. The second address wraps modulo 2^16. Partial loads replace only one half of the old destination value and keep the other half. A byte load instead fills the whole word with the sign-extended byte.

Both memories are synchronous. A byte read strobed in one cycle gives its data in the next cycle. A write strobe commits the byte at the clock edge that closes the strobe cycle.

Top module: `lsu_byte_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, wb_en, dmem_rd, dmem_wr and pmem_rd are all low.
- R2: A word store (op 0) writes src[7:0] at address A in the first access cycle, then src[15:0]'s upper byte src[15:8] at A+1 in the very next cycle.
- R3: A low-byte store (op 1) writes src[7:0] at A and a high-byte store (op 2) writes src[15:8] at A, each with exactly one write strobe.
- R4: A low-half load (op 3) reads the data byte at A and returns {dest[15:8], byte}.
- R5: A high-half load (op 4) reads the data byte at A and returns {byte, dest[7:0]}.
- R6: A byte load (op 5) reads the data byte at A and returns it sign-extended, with bit 7 copied into bits 15:8.
- R7: A program load (op 6) reads the program ROM at A and then at A+1 and returns {byte(A+1), byte(A)}. No data memory strobe is raised during it.
- R8: The second byte of a word access at address 0xFFFF goes to address 0x0000.
- R9: A request is accepted in a cycle where busy is low and req_valid is high. busy rises in the next cycle. done is a single-cycle pulse, with busy high in the same cycle. It comes 2 cycles after acceptance for one-byte operations and 3 cycles after for ops 0 and 6. busy falls in the cycle after done.
- R10: A request made while busy is high, or one that carries op code 7, is ignored: no strobe follows and busy stays as it was.
- R11: At most one of dmem_rd, dmem_wr and pmem_rd is high in any cycle, and none is high while busy is low.
- R12: wb_en is high only together with done, and only for ops 3 to 6. It is low on the done pulse of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation: 0 word store, 1 low store, 2 high store, 3 low load, 4 high load, 5 byte load, 6 program load, 7 none |
| req_addr | input | 16 | Byte address from the address register |
| req_src | input | 16 | Source register value for stores |
| req_dest | input | 16 | Old destination register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Write-back value valid (loads) |
| wb_data | output | 16 | Write-back value |
| dmem_addr | output | 16 | Data memory byte address |
| dmem_rd | output | 1 | Data memory read strobe |
| dmem_wr | output | 1 | Data memory write strobe |
| dmem_wdata | output | 8 | Data memory write byte |
| dmem_rdata | input | 8 | Data memory read byte, one cycle after the read strobe |
| pmem_addr | output | 16 | Program memory byte address |
| pmem_rd | output | 1 | Program memory read strobe |
| pmem_rdata | input | 8 | Program memory read byte, one cycle after the read strobe |

## Verification
Two things can land in the same cycle: the done pulse that ends one operation, and a new request from the pipeline. The bench raises req_valid for exactly the done cycle of a low-byte store. It does the same in the middle of a word store. After each case it watches the memory strobes and busy for several cycles, and it expects neither operation to be started. The wrap at address 0xFFFF also combines with the two-cycle sequencing. It is checked for both a word store and a program load, by looking at the addresses and at the bytes that are returned or written.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [2:0] {
        OP_STW  = 3'd0,
        OP_STL  = 3'd1,
        OP_STH  = 3'd2,
        OP_LDL  = 3'd3,
        OP_LDH  = 3'd4,
        OP_LDB  = 3'd5,
        OP_LDP  = 3'd6,
        OP_NONE = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2,
        PH_FINISH = 2'd3
    } phase_e;

    function automatic logic op_is_pair(op_e op);
        return (op == OP_STW) || (op == OP_LDP);
    endfunction

    function automatic logic op_is_store(op_e op);
        return (op == OP_STW) || (op == OP_STL) || (op == OP_STH);
    endfunction

    function automatic logic op_is_data_load(op_e op);
        return (op == OP_LDL) || (op == OP_LDH) || (op == OP_LDB);
    endfunction

    function automatic logic op_is_load(op_e op);
        return op_is_data_load(op) || (op == OP_LDP);
    endfunction

endpackage

// File: rtl/lsu_byte_addr.sv
module lsu_byte_addr #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic              second_i,
    output logic [ADDR_W-1:0] addr_o
);
    // Second byte sits one above the base; the sum wraps at the top of the space.
    always_comb begin
        addr_o = base_i + {{(ADDR_W-1){1'b0}}, second_i};
    end
endmodule

// File: rtl/lsu_store_sel.sv
module lsu_store_sel #(
    parameter int BYTE_W = 8
) (
    input  logic [2*BYTE_W-1:0] word_i,
    input  logic                upper_i,
    output logic [BYTE_W-1:0]   byte_o
);
    always_comb begin
        byte_o = upper_i ? word_i[2*BYTE_W-1:BYTE_W] : word_i[BYTE_W-1:0];
    end
endmodule

// File: rtl/lsu_merge.sv
module lsu_merge
    import lsu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  op_e                 op_i,
    input  logic [2*BYTE_W-1:0] dest_i,
    input  logic [BYTE_W-1:0]   lo_i,
    input  logic [BYTE_W-1:0]   rd_i,
    output logic [2*BYTE_W-1:0] wb_o
);
    localparam int WORD_W = 2 * BYTE_W;

    always_comb begin
        unique case (op_i)
            OP_LDL:  wb_o = {dest_i[WORD_W-1:BYTE_W], rd_i};
            OP_LDH:  wb_o = {rd_i, dest_i[BYTE_W-1:0]};
            OP_LDB:  wb_o = {{BYTE_W{rd_i[BYTE_W-1]}}, rd_i};
            OP_LDP:  wb_o = {rd_i, lo_i};
            default: wb_o = dest_i;
        endcase
    end
endmodule

// File: rtl/lsu_byte_unit.sv
module lsu_byte_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*BYTE_W-1:0] req_src,
    input  logic [2*BYTE_W-1:0] req_dest,
    output logic                busy,
    output logic                done,
    output logic                wb_en,
    output logic [2*BYTE_W-1:0] wb_data,
    output logic [ADDR_W-1:0]   dmem_addr,
    output logic                dmem_rd,
    output logic                dmem_wr,
    output logic [BYTE_W-1:0]   dmem_wdata,
    input  logic [BYTE_W-1:0]   dmem_rdata,
    output logic [ADDR_W-1:0]   pmem_addr,
    output logic                pmem_rd,
    input  logic [BYTE_W-1:0]   pmem_rdata
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        phase_e              phase;
        op_e                 op;
        logic [ADDR_W-1:0]   base;
        logic [WORD_W-1:0]   src;
        logic [WORD_W-1:0]   dest;
        logic [BYTE_W-1:0]   lo;
    } state_t;

    localparam state_t ST_RST = '{
        phase: PH_IDLE,
        op:    OP_NONE,
        base:  '0,
        src:   '0,
        dest:  '0,
        lo:    '0
    };

    state_t st_d, st_q;

    logic              second_byte;
    logic              in_access;
    logic              upper_sel;
    logic [ADDR_W-1:0] byte_addr;
    logic [BYTE_W-1:0] rd_byte;
    op_e               req_op_e;

    assign req_op_e    = op_e'(req_op);
    assign second_byte = (st_q.phase == PH_SECOND);
    assign in_access   = (st_q.phase == PH_FIRST) || second_byte;
    assign upper_sel   = second_byte || (st_q.op == OP_STH);
    assign rd_byte     = (st_q.op == OP_LDP) ? pmem_rdata : dmem_rdata;

    lsu_byte_addr #(.ADDR_W(ADDR_W)) u_addr (
        .base_i   (st_q.base),
        .second_i (second_byte),
        .addr_o   (byte_addr)
    );

    lsu_store_sel #(.BYTE_W(BYTE_W)) u_sel (
        .word_i  (st_q.src),
        .upper_i (upper_sel),
        .byte_o  (dmem_wdata)
    );

    lsu_merge #(.BYTE_W(BYTE_W)) u_merge (
        .op_i   (st_q.op),
        .dest_i (st_q.dest),
        .lo_i   (st_q.lo),
        .rd_i   (rd_byte),
        .wb_o   (wb_data)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid && (req_op_e != OP_NONE)) begin
                    st_d.phase = PH_FIRST;
                    st_d.op    = req_op_e;
                    st_d.base  = req_addr;
                    st_d.src   = req_src;
                    st_d.dest  = req_dest;
                end
            end
            PH_FIRST: begin
                st_d.phase = op_is_pair(st_q.op) ? PH_SECOND : PH_FINISH;
            end
            PH_SECOND: begin
                // the low byte of a program word arrives one cycle after its read
                st_d.lo    = pmem_rdata;
                st_d.phase = PH_FINISH;
            end
            PH_FINISH: begin
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.phase != PH_IDLE);
    assign done      = (st_q.phase == PH_FINISH);
    assign wb_en     = done && op_is_load(st_q.op);
    assign dmem_addr = byte_addr;
    assign pmem_addr = byte_addr;
    assign dmem_wr   = in_access && op_is_store(st_q.op);
    assign dmem_rd   = in_access && op_is_data_load(st_q.op);
    assign pmem_rd   = in_access && (st_q.op == OP_LDP);

endmodule

// File: rtl/lsu_byte_unit_chk.sv
module lsu_byte_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              wb_en,
    input logic [ADDR_W-1:0] dmem_addr,
    input logic              dmem_rd,
    input logic              dmem_wr,
    input logic [ADDR_W-1:0] pmem_addr,
    input logic              pmem_rd
);
    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dmem_rd, dmem_wr, pmem_rd}));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(dmem_rd || dmem_wr || pmem_rd));

    assert_done_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    assert_busy_needs_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    assert_wb_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R2, R8: back-to-back write strobes step the address by one, wrapping
    assert_store_pair_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_wr && $past(dmem_wr)) |-> (dmem_addr == ADDR_W'($past(dmem_addr) + 1'b1)));

    // R7, R8: back-to-back program reads step the address by one, wrapping
    assert_prog_pair_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pmem_rd && $past(pmem_rd)) |-> (pmem_addr == ADDR_W'($past(pmem_addr) + 1'b1)));

    assert_prog_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pmem_rd |-> !(dmem_rd || dmem_wr));
endmodule

bind lsu_byte_unit lsu_byte_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .wb_en     (wb_en),
    .dmem_addr (dmem_addr),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr),
    .pmem_addr (pmem_addr),
    .pmem_rd   (pmem_rd)
);

// File: tb/lsu_byte_unit_tb_top.sv
module lsu_byte_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd7;
    logic [15:0] req_addr = '0;
    logic [15:0] req_src = '0;
    logic [15:0] req_dest = '0;
    logic        busy, done, wb_en, dmem_rd, dmem_wr, pmem_rd;
    logic [15:0] wb_data, dmem_addr, pmem_addr;
    logic [7:0]  dmem_wdata;
    logic [7:0]  dmem_rdata = '0;
    logic [7:0]  pmem_rdata = '0;

    logic [7:0]  dmem [0:255];
    int          checks = 0;
    int          failures = 0;

    // captured trace of the last operation
    logic [15:0] s_addr [0:3];
    logic [2:0]  s_kind [0:3];   // 1 data write, 2 data read, 4 program read
    logic [7:0]  s_wdata [0:3];
    int          s_n;
    int          cyc_done;
    logic [15:0] got_wb;
    logic        got_wben;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_byte_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_src(req_src), .req_dest(req_dest),
        .busy(busy), .done(done), .wb_en(wb_en), .wb_data(wb_data),
        .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .pmem_addr(pmem_addr), .pmem_rd(pmem_rd), .pmem_rdata(pmem_rdata)
    );

    // memory models: program byte at i is i ^ 0x5A
    always @(posedge clk) begin
        if (dmem_wr) dmem[dmem_addr[7:0]] <= dmem_wdata;
        if (dmem_rd) dmem_rdata <= dmem[dmem_addr[7:0]];
        if (pmem_rd) pmem_rdata <= pmem_addr[7:0] ^ 8'h5A;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // issue one request and trace it until done (sampled at negedges)
    task automatic run_op(input logic [2:0] op, input logic [15:0] a,
                          input logic [15:0] src, input logic [15:0] dst);
        int cyc;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_src = src; req_dest = dst;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd7;
        s_n = 0; cyc_done = 0; got_wb = '0; got_wben = 1'b0;
        cyc = 1;
        chk("R9 busy after accept", busy, 1'b1);
        while (cyc < 10) begin
            if ($countones({dmem_rd, dmem_wr, pmem_rd}) > 1) chk("R11 one strobe", 1, 0);
            if (dmem_wr || dmem_rd || pmem_rd) begin
                if (s_n < 4) begin
                    s_kind[s_n]  = {pmem_rd, dmem_rd, dmem_wr};
                    s_addr[s_n]  = pmem_rd ? pmem_addr : dmem_addr;
                    s_wdata[s_n] = dmem_wdata;
                end
                s_n++;
            end
            if (done) begin
                cyc_done = cyc; got_wb = wb_data; got_wben = wb_en;
                break;
            end
            @(negedge clk);
            cyc++;
        end
        if (cyc_done == 0) chk("R9 done timeout", 0, 1);
        @(negedge clk);
        chk("R9 busy falls after done", {busy, done}, 2'b00);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset outputs", {busy, done, wb_en, dmem_rd, dmem_wr, pmem_rd}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {busy, done, wb_en, dmem_rd, dmem_wr, pmem_rd}, 6'b0);
    endtask

    task automatic t_store_word();
        run_op(3'd0, 16'h0010, 16'hBEEF, 16'h0);
        chk("R2 strobe count", s_n, 2);
        chk("R2 first write", {s_kind[0], s_addr[0], s_wdata[0]}, {3'b001, 16'h0010, 8'hEF});
        chk("R2 second write", {s_kind[1], s_addr[1], s_wdata[1]}, {3'b001, 16'h0011, 8'hBE});
        chk("R9 word latency", cyc_done, 3);
        chk("R12 no wb on store", got_wben, 1'b0);
        chk("R2 memory", {dmem[8'h11], dmem[8'h10]}, 16'hBEEF);
    endtask

    task automatic t_store_halves();
        run_op(3'd1, 16'h0020, 16'h1234, 16'h0);
        chk("R3 low count", s_n, 1);
        chk("R3 low write", {s_kind[0], s_addr[0], s_wdata[0]}, {3'b001, 16'h0020, 8'h34});
        chk("R9 byte latency", cyc_done, 2);
        run_op(3'd2, 16'h0021, 16'h1234, 16'h0);
        chk("R3 high count", s_n, 1);
        chk("R3 high write", {s_kind[0], s_addr[0], s_wdata[0]}, {3'b001, 16'h0021, 8'h12});
        chk("R12 no wb on store", got_wben, 1'b0);
    endtask

    task automatic t_loads();
        dmem[8'h30] = 8'hA5; dmem[8'h31] = 8'hC3; dmem[8'h32] = 8'h80; dmem[8'h33] = 8'h7F;
        run_op(3'd3, 16'h0030, 16'h0, 16'h1234);
        chk("R4 low merge", got_wb, 16'h12A5);
        chk("R12 wb on load", got_wben, 1'b1);
        chk("R4 one read", {s_n[2:0], s_kind[0], s_addr[0]}, {3'd1, 3'b010, 16'h0030});
        run_op(3'd4, 16'h0031, 16'h0, 16'h1234);
        chk("R5 high merge", got_wb, 16'hC334);
        chk("R9 byte latency", cyc_done, 2);
        run_op(3'd5, 16'h0032, 16'h0, 16'h1234);
        chk("R6 negative byte", got_wb, 16'hFF80);
        run_op(3'd5, 16'h0033, 16'h0, 16'hFFFF);
        chk("R6 positive byte", got_wb, 16'h007F);
    endtask

    task automatic t_prog();
        run_op(3'd6, 16'h0040, 16'h0, 16'hFFFF);
        chk("R7 program word", got_wb, 16'h1B1A);
        chk("R7 two program reads", {s_n[2:0], s_kind[0], s_kind[1]}, {3'd2, 3'b100, 3'b100});
        chk("R7 addresses", {s_addr[0], s_addr[1]}, {16'h0040, 16'h0041});
        chk("R9 program latency", cyc_done, 3);
        chk("R12 wb on program load", got_wben, 1'b1);
    endtask

    task automatic t_wrap();
        run_op(3'd6, 16'hFFFF, 16'h0, 16'h0);
        chk("R8 program wrap addr", {s_addr[0], s_addr[1]}, {16'hFFFF, 16'h0000});
        chk("R8 program wrap data", got_wb, 16'h5AA5);
        run_op(3'd0, 16'hFFFF, 16'h5566, 16'h0);
        chk("R8 store wrap addr", {s_addr[0], s_addr[1]}, {16'hFFFF, 16'h0000});
        chk("R8 store wrap data", {s_wdata[0], s_wdata[1]}, {8'h66, 8'h55});
    endtask

    task automatic watch_quiet(input string req);
        int strobes = 0;
        int busies = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (dmem_rd || dmem_wr || pmem_rd) strobes++;
            if (busy) busies++;
        end
        chk(req, {strobes[15:0], busies[15:0]}, 32'h0);
    endtask

    task automatic t_ignore();
        // reserved op code
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd7; req_addr = 16'h0050;
        @(negedge clk);
        req_valid = 1'b0;
        watch_quiet("R10 reserved op ignored");
        // request presented exactly in the done cycle of another operation
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_addr = 16'h0060; req_src = 16'h00AB;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        req_valid = 1'b1; req_op = 3'd2; req_addr = 16'h0061; req_src = 16'hCD00;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd7;
        chk("R10 idle after done", busy, 1'b0);
        watch_quiet("R10 request in done cycle");
        chk("R10 byte not written", dmem[8'h61] === 8'hCD, 1'b0);
        // request during the first access cycle of a word store
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd0; req_addr = 16'h0070; req_src = 16'h1111;
        @(negedge clk);
        req_op = 3'd1; req_addr = 16'h0080;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd7;
        while (busy) @(negedge clk);
        watch_quiet("R10 request while busy");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
        t_reset();
        t_store_word();
        t_store_halves();
        t_loads();
        t_prog();
        t_wrap();
        t_ignore();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hang expected=finish");
        finish_run();
    end
endmodule